// File: doc/BRIEF.md
# Addressed SPI Command Decoder for a Dual Digital Potentiometer

This block is the serial front end of a two-channel digital potentiometer controller. It acts as an SPI mode-0 slave and samples chip select, serial clock, serial input and the pause input with the controller's system clock. It checks an identification byte against a fixed device-type nibble and the pin-strapped address. It then decodes an instruction byte and turns each accepted transaction into single-cycle strobes toward a separate register bank, which holds the wiper and stored-setting registers.

Commands that change state are committed only when chip select is released after an exact, complete frame. Read commands request data from the bank and shift it out on the serial output. The step command has no fixed length: every later serial clock pulse moves the selected wiper one tap, up when the serial input is high and down when it is low. A pause input can freeze a transaction in the middle of a frame, and it floats the serial output while the frame is paused.

Top module: `pot_spi_decoder`

## Requirements
- R1: `so_oe` is low out of reset and whenever chip select is high. It is high only while the data byte of a read command is being shifted out.
- R2: The first byte after chip select falls must be `0101` (MSB first), then two zero bits, then the two strap bits equal to `strap_addr`. Any mismatch makes the rest of the frame produce no strobe, request or step.
- R3: The second byte is taken MSB first: bits 7..4 give `op_code`, bits 3..2 give `reg_sel`, bit 1 is ignored and bit 0 gives `pot_sel`. These fields hold their values while the strobes that use them are asserted.
- R4: Write wiper (`1010`) and write stored register (`1100`) take a third byte whose low six bits become `wr_data`. One `op_strobe` pulse is issued when chip select rises after exactly 24 bits.
- R5: The transfer opcodes `1101`, `1110`, `0001` and `1000` issue one `op_strobe` when chip select rises after exactly 16 bits. Any extra clock pulse cancels the command.
- R6: If chip select rises with a byte incomplete, no `op_strobe` is issued.
- R7: Read wiper (`1001`), read stored register (`1011`) and read status (`0101`) pulse `rd_req` once, when the instruction byte completes. During the third byte, `so` presents two zeros and then `rd_data` MSB first. Each bit changes after a falling SCK edge so that it can be sampled on the next rising edge.
- R8: After opcode `0010`, each rising SCK edge gives one `step_pulse`, with `step_up` equal to the SI bit sampled on that edge. This continues until chip select rises.
- R9: Driving the pause input low while SCK is low freezes the frame: SCK edges are ignored and `so_oe` drops. Raising it while SCK is low resumes the frame where it stopped.
- R10: An opcode outside the ten listed ones makes the decoder ignore the rest of the frame. No strobe, request or step follows.
- R11: After reset, no command is accepted until chip select has been seen falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| strap_addr | input | ADDR_W | Pin-strapped device address |
| rd_data | input | DATA_W | Read value from the register bank (status in bit 0 for status reads) |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the serial data pad |
| op_strobe | output | 1 | Commit pulse for write and transfer commands |
| op_code | output | 4 | Decoded opcode |
| pot_sel | output | 1 | Selected potentiometer |
| reg_sel | output | 2 | Selected stored register |
| wr_data | output | DATA_W | Write value from the third byte |
| rd_req | output | 1 | Read request pulse |
| step_pulse | output | 1 | One wiper step |
| step_up | output | 1 | Direction of the step, 1 toward the high end |

## Verification
The assertions assume that the serial pins change slowly compared with the system clock. Each SCK level must last several system cycles longer than the synchronizer depth, so that every edge is seen exactly once. They also assume that the pause input and chip select change only while SCK is low. The stimulus drives every pin on the falling system-clock edge and holds each SCK half-period for six cycles. It moves the pause input and chip select only after SCK has returned low, so it stays inside these assumptions.

// File: rtl/pot_spi_pkg.sv
package pot_spi_pkg;

   localparam int BYTE_BITS = 8;
   localparam int CNT_W     = $clog2(BYTE_BITS);
   localparam logic [3:0] DEV_TYPE = 4'b0101;

   typedef enum logic [3:0] {
      OP_RD_WIPER   = 4'b1001,
      OP_WR_WIPER   = 4'b1010,
      OP_RD_STORE   = 4'b1011,
      OP_WR_STORE   = 4'b1100,
      OP_LOAD_WIPER = 4'b1101,
      OP_SAVE_WIPER = 4'b1110,
      OP_LOAD_ALL   = 4'b0001,
      OP_SAVE_ALL   = 4'b1000,
      OP_STEP       = 4'b0010,
      OP_STATUS     = 4'b0101
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ID, ST_INSTR, ST_DATA, ST_DONE, ST_STEP, ST_SKIP
   } st_e;

   typedef enum logic [2:0] {
      K_BAD, K_XFER, K_READ, K_WRITE, K_STEP
   } cls_e;

   function automatic cls_e classify(input logic [3:0] code);
      case (code)
         OP_RD_WIPER, OP_RD_STORE, OP_STATUS:                     return K_READ;
         OP_WR_WIPER, OP_WR_STORE:                                return K_WRITE;
         OP_LOAD_WIPER, OP_SAVE_WIPER, OP_LOAD_ALL, OP_SAVE_ALL:  return K_XFER;
         OP_STEP:                                                 return K_STEP;
         default:                                                 return K_BAD;
      endcase
   endfunction

endpackage

// File: rtl/pot_spi_sync.sv
module pot_spi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 1) begin : g_single
         logic r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= RST_VAL;
            else        r_q <= d;
         end
         assign q = r_q;
      end else begin : g_chain
         logic [STAGES-1:0] ch_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ch_q <= {STAGES{RST_VAL}};
            else        ch_q <= {ch_q[STAGES-2:0], d};
         end
         assign q = ch_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pot_spi_front.sv
module pot_spi_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   input  logic hold_n,
   output logic cs_q,
   output logic cs_fall,
   output logic cs_rise,
   output logic sck_rise,
   output logic sck_fall,
   output logic si_q,
   output logic held
);
   localparam int NPIN = 4;
   // reset levels, index order: cs, sck, si, hold
   localparam logic [NPIN-1:0] PIN_RST = 4'b1000;

   logic [NPIN-1:0] raw, syn;
   logic cs_prev_q, sck_prev_q, held_q;

   assign raw = {hold_n, si, sck, cs_n};

   for (genvar g = 0; g < NPIN; g++) begin : g_pin
      pot_spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[g])) u_sync (
         .clk(clk), .rst_n(rst_n), .d(raw[g]), .q(syn[g]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev_q  <= 1'b0;
         sck_prev_q <= 1'b0;
         held_q     <= 1'b0;
      end else begin
         cs_prev_q  <= syn[0];
         sck_prev_q <= syn[1];
         if (syn[0])       held_q <= 1'b0;
         else if (!syn[1]) held_q <= !syn[3];
      end
   end

   assign cs_q     = syn[0];
   assign si_q     = syn[2];
   assign held     = held_q;
   assign cs_fall  = cs_prev_q & ~syn[0];
   assign cs_rise  = ~cs_prev_q & syn[0];
   assign sck_rise = syn[1] & ~sck_prev_q & ~syn[0] & ~held_q;
   assign sck_fall = ~syn[1] & sck_prev_q & ~syn[0] & ~held_q;
endmodule

// File: rtl/pot_spi_fsm.sv
module pot_spi_fsm
   import pot_spi_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_q,
   input  logic              cs_fall,
   input  logic              cs_rise,
   input  logic              sck_rise,
   input  logic              si_q,
   input  logic [ADDR_W-1:0] strap_addr,
   output logic              op_strobe,
   output logic [3:0]        op_code,
   output logic              pot_sel,
   output logic [1:0]        reg_sel,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_req,
   output logic              step_pulse,
   output logic              step_up,
   output logic              rd_active,
   output logic              rd_window,
   output logic              bit_zero,
   output logic              skip
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

   st_e                  state_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [BYTE_BITS-2:0] sh_q;
   logic                 is_rd_q;
   logic [BYTE_BITS-1:0] byte_w;
   logic                 id_ok;
   cls_e                 cur_cls, new_cls;

   assign byte_w  = {sh_q, si_q};
   assign id_ok   = (byte_w[7:4] == DEV_TYPE) && (byte_w[3:ADDR_W] == '0)
                    && (byte_w[ADDR_W-1:0] == strap_addr);
   assign cur_cls = classify(op_code);
   assign new_cls = classify(byte_w[7:4]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         sh_q       <= '0;
         is_rd_q    <= 1'b0;
         op_code    <= '0;
         reg_sel    <= '0;
         pot_sel    <= 1'b0;
         wr_data    <= '0;
         op_strobe  <= 1'b0;
         rd_req     <= 1'b0;
         step_pulse <= 1'b0;
         step_up    <= 1'b0;
      end else begin
         op_strobe  <= 1'b0;
         rd_req     <= 1'b0;
         step_pulse <= 1'b0;
         if (cs_fall) begin
            state_q <= ST_ID;
            cnt_q   <= '0;
            sh_q    <= '0;
            is_rd_q <= 1'b0;
         end else if (cs_q) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
            if (cs_rise && state_q == ST_DONE && (cur_cls == K_WRITE || cur_cls == K_XFER))
               op_strobe <= 1'b1;
         end else if (sck_rise) begin
            sh_q  <= byte_w[BYTE_BITS-2:0];
            cnt_q <= cnt_q + 1'b1;
            case (state_q)
               ST_ID: if (cnt_q == LAST_BIT) state_q <= id_ok ? ST_INSTR : ST_SKIP;
               ST_INSTR: if (cnt_q == LAST_BIT) begin
                  op_code <= byte_w[7:4];
                  reg_sel <= byte_w[3:2];
                  pot_sel <= byte_w[0];
                  case (new_cls)
                     K_XFER:  state_q <= ST_DONE;
                     K_WRITE: state_q <= ST_DATA;
                     K_STEP:  state_q <= ST_STEP;
                     K_READ: begin
                        state_q <= ST_DATA;
                        is_rd_q <= 1'b1;
                        rd_req  <= 1'b1;
                     end
                     default: state_q <= ST_SKIP;
                  endcase
               end
               ST_DATA: if (cnt_q == LAST_BIT) begin
                  state_q <= ST_DONE;
                  if (!is_rd_q) wr_data <= byte_w[DATA_W-1:0];
               end
               ST_DONE: state_q <= ST_SKIP;
               ST_STEP: begin
                  step_pulse <= 1'b1;
                  step_up    <= si_q;
               end
               default: ;
            endcase
         end
      end
   end

   assign rd_active = is_rd_q && state_q == ST_DATA;
   assign rd_window = is_rd_q && (state_q == ST_DATA || state_q == ST_DONE);
   assign bit_zero  = cnt_q == '0;
   assign skip      = state_q == ST_SKIP;
endmodule

// File: rtl/pot_spi_sotx.sv
module pot_spi_sotx
   import pot_spi_pkg::*;
#(
   parameter int DATA_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_fall,
   input  logic              rd_active,
   input  logic              rd_window,
   input  logic              bit_zero,
   input  logic              cs_q,
   input  logic              held,
   input  logic [DATA_W-1:0] rd_data,
   output logic              so,
   output logic              so_oe
);
   localparam int PAD = BYTE_BITS - DATA_W;

   logic [BYTE_BITS-1:0] out_q;
   logic                 oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         oe_q  <= 1'b0;
      end else begin
         oe_q <= ~cs_q & ~held & rd_window;
         if (sck_fall && rd_active) begin
            if (bit_zero) out_q <= {{PAD{1'b0}}, rd_data};
            else          out_q <= {out_q[BYTE_BITS-2:0], 1'b0};
         end
      end
   end

   assign so    = out_q[BYTE_BITS-1];
   assign so_oe = oe_q;
endmodule

// File: rtl/pot_spi_decoder.sv
module pot_spi_decoder
   import pot_spi_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   input  logic              hold_n,
   input  logic [ADDR_W-1:0] strap_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              so,
   output logic              so_oe,
   output logic              op_strobe,
   output logic [3:0]        op_code,
   output logic              pot_sel,
   output logic [1:0]        reg_sel,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_req,
   output logic              step_pulse,
   output logic              step_up
);
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 3) begin : g_bad_addr
      $error("ADDR_W must be 1 to 3");
   end
   if (DATA_W < 1 || DATA_W > BYTE_BITS - 1) begin : g_bad_data
      $error("DATA_W must be 1 to 7");
   end

   logic cs_q, cs_fall, cs_rise, sck_rise, sck_fall, si_q, held;
   logic rd_active, rd_window, bit_zero, skip;

   pot_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
      .cs_q(cs_q), .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise),
      .sck_fall(sck_fall), .si_q(si_q), .held(held));

   pot_spi_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .sck_rise(sck_rise), .si_q(si_q), .strap_addr(strap_addr),
      .op_strobe(op_strobe), .op_code(op_code), .pot_sel(pot_sel), .reg_sel(reg_sel),
      .wr_data(wr_data), .rd_req(rd_req), .step_pulse(step_pulse), .step_up(step_up),
      .rd_active(rd_active), .rd_window(rd_window), .bit_zero(bit_zero), .skip(skip));

   pot_spi_sotx #(.DATA_W(DATA_W)) u_sotx (
      .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .rd_active(rd_active),
      .rd_window(rd_window), .bit_zero(bit_zero), .cs_q(cs_q), .held(held),
      .rd_data(rd_data), .so(so), .so_oe(so_oe));
endmodule

// File: rtl/pot_spi_decoder_chk.sv
module pot_spi_decoder_chk
   import pot_spi_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cs_q,
   input logic       cs_rise,
   input logic       held,
   input logic       skip,
   input logic       so_oe,
   input logic       op_strobe,
   input logic       rd_req,
   input logic       step_pulse,
   input logic [3:0] op_code
);
   // R1
   so_off_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q |=> !so_oe);

   // R6
   commit_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_strobe |-> $past(cs_rise));

   // R9
   pause_floats_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held |=> !so_oe);

   // R8
   one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_strobe, rd_req, step_pulse}));

   // R8
   step_needs_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_pulse |-> op_code == OP_STEP);

   // R7
   read_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (op_code == OP_RD_WIPER || op_code == OP_RD_STORE || op_code == OP_STATUS));

   // R10
   skip_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip |=> !op_strobe);
endmodule

bind pot_spi_decoder pot_spi_decoder_chk chk_i (
   .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .cs_rise(cs_rise), .held(held),
   .skip(skip), .so_oe(so_oe), .op_strobe(op_strobe), .rd_req(rd_req),
   .step_pulse(step_pulse), .op_code(op_code));

// File: tb/pot_spi_decoder_tb_top.sv
module pot_spi_decoder_tb_top;
   localparam int N    = 2;
   localparam int HALF = 6;
   localparam logic [1:0] STRAP = 2'b01;
   localparam logic [7:0] ID_OK = {4'b0101, 2'b00, STRAP};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
   logic [5:0] rd_data = '0;
   logic so, so_oe, op_strobe, pot_sel, rd_req, step_pulse, step_up;
   logic [3:0] op_code;
   logic [1:0] reg_sel;
   logic [5:0] wr_data;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pot_spi_decoder #(.SYNC_STAGES(N), .ADDR_W(2), .DATA_W(6)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
      .strap_addr(STRAP), .rd_data(rd_data), .so(so), .so_oe(so_oe),
      .op_strobe(op_strobe), .op_code(op_code), .pot_sel(pot_sel), .reg_sel(reg_sel),
      .wr_data(wr_data), .rd_req(rd_req), .step_pulse(step_pulse), .step_up(step_up));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int h_cs[N+2], h_sck[N+2], h_si[N+2], h_hold[N+2];
   int m_state, m_pos, m_acc, m_rd, m_held, m_out, m_oe;
   int m_op, m_reg, m_pot, m_wd, m_commit, m_rdq, m_step, m_up;
   // m_state: 0 idle, 1 id, 2 instr, 3 data, 4 done, 5 step, 6 skip

   function automatic int kind(input int op);
      if (op == 9 || op == 11 || op == 5) return 1;            // read
      if (op == 10 || op == 12) return 2;                      // write
      if (op == 13 || op == 14 || op == 1 || op == 8) return 3; // transfer
      if (op == 2) return 4;                                    // step
      return 0;
   endfunction

   always @(posedge clk) begin : model
      int scs, pcs, ssck, psck, ssi, shold, b;
      bit rise, fall;
      if (!rst_n) begin
         for (int k = 0; k < N + 2; k++) begin
            h_cs[k] = 0; h_sck[k] = 0; h_si[k] = 0; h_hold[k] = 1;
         end
         m_state = 0; m_pos = 0; m_acc = 0; m_rd = 0; m_held = 0; m_out = 0; m_oe = 0;
         m_op = 0; m_reg = 0; m_pot = 0; m_wd = 0; m_commit = 0; m_rdq = 0; m_step = 0; m_up = 0;
      end else begin
         for (int k = N + 1; k > 0; k--) begin
            h_cs[k] = h_cs[k-1]; h_sck[k] = h_sck[k-1]; h_si[k] = h_si[k-1]; h_hold[k] = h_hold[k-1];
         end
         h_cs[0] = cs_n; h_sck[0] = sck; h_si[0] = si; h_hold[0] = hold_n;
         scs = h_cs[N]; pcs = h_cs[N+1]; ssck = h_sck[N]; psck = h_sck[N+1];
         ssi = h_si[N]; shold = h_hold[N];
         rise = (ssck == 1 && psck == 0 && scs == 0 && m_held == 0);
         fall = (ssck == 0 && psck == 1 && scs == 0 && m_held == 0);
         m_commit = 0; m_rdq = 0; m_step = 0;
         m_oe = (scs == 0 && m_held == 0 && m_rd == 1 && (m_state == 3 || m_state == 4)) ? 1 : 0;
         if (fall && m_state == 3 && m_rd == 1)
            m_out = (m_pos == 0) ? int'(rd_data) : ((m_out * 2) % 256);
         if (pcs == 1 && scs == 0) begin
            m_state = 1; m_pos = 0; m_acc = 0; m_rd = 0;
         end else if (scs == 1) begin
            if (pcs == 0 && m_state == 4 && (kind(m_op) == 2 || kind(m_op) == 3)) m_commit = 1;
            m_state = 0; m_pos = 0;
         end else if (rise) begin
            m_acc = (m_acc * 2 + ssi) % 256;
            b = m_acc;
            if (m_state == 1 && m_pos == 7) m_state = (b == int'(ID_OK)) ? 2 : 6;
            else if (m_state == 2 && m_pos == 7) begin
               m_op = b / 16; m_reg = (b / 4) % 4; m_pot = b % 2;
               case (kind(m_op))
                  1: begin m_state = 3; m_rd = 1; m_rdq = 1; end
                  2: m_state = 3;
                  3: m_state = 4;
                  4: m_state = 5;
                  default: m_state = 6;
               endcase
            end else if (m_state == 3 && m_pos == 7) begin
               m_state = 4;
               if (m_rd == 0) m_wd = b % 64;
            end else if (m_state == 4) m_state = 6;
            else if (m_state == 5) begin m_step = 1; m_up = ssi; end
            m_pos = (m_pos + 1) % 8;
         end
         if (scs == 1) m_held = 0;
         else if (ssck == 0) m_held = (shold == 0) ? 1 : 0;
      end
   end

   // per-cycle comparison and event monitor
   int n_commit = 0, n_rdreq = 0, n_step = 0, n_up = 0;
   int l_op, l_reg, l_pot, l_wd;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R4 op_strobe", op_strobe, m_commit);
         check("R7 rd_req", rd_req, m_rdq);
         check("R8 step_pulse", step_pulse, m_step);
         check("R1 so_oe", so_oe, m_oe);
         if (m_commit == 1 || m_rdq == 1) begin
            check("R3 op_code", op_code, m_op);
            check("R3 reg_sel", reg_sel, m_reg);
            check("R3 pot_sel", pot_sel, m_pot);
         end
         if (m_commit == 1) check("R4 wr_data", wr_data, m_wd);
         if (m_step == 1) check("R8 step_up", step_up, m_up);
         if (m_oe == 1) check("R7 so", so, m_out / 128);
         if (op_strobe) begin n_commit++; l_op = op_code; l_reg = reg_sel; l_pot = pot_sel; l_wd = wr_data; end
         if (rd_req) begin n_rdreq++; l_op = op_code; l_reg = reg_sel; l_pot = pot_sel; end
         if (step_pulse) begin n_step++; if (step_up) n_up++; end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sbit(input logic b, output logic r);
      si = b;
      wait_n(HALF);
      sck = 1'b1;
      r = so;
      wait_n(HALF);
      sck = 1'b0;
   endtask

   task automatic sbits(input logic [7:0] v, input int hi, input int lo, inout logic [7:0] r);
      for (int i = hi; i >= lo; i--) begin
         logic b;
         sbit(v[i], b);
         r[i] = b;
      end
   endtask

   task automatic open_frame;
      cs_n = 1'b0;
      wait_n(HALF);
   endtask

   task automatic close_frame;
      wait_n(HALF);
      cs_n = 1'b1;
      wait_n(4 * HALF);
   endtask

   task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input int nb, input logic [7:0] b2,
                        output logic [7:0] r);
      logic [7:0] d;
      r = '0;
      open_frame();
      sbits(b0, 7, 0, d);
      sbits(b1, 7, 0, d);
      if (nb > 2) sbits(b2, 7, 0, r);
      close_frame();
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      int bc, br, bs, bu;
      logic [7:0] r;
      cs_n = 1'b0;
      wait_n(4);
      rst_n = 1'b1;
      wait_n(2);
      check("R1 reset so_oe", so_oe, 0);
      check("R4 reset op_strobe", op_strobe, 0);

      // R11: full write frame without a preceding CS fall
      bc = n_commit;
      sbits(ID_OK, 7, 0, r);
      sbits(8'hA1, 7, 0, r);
      sbits(8'h2A, 7, 0, r);
      close_frame();
      check("R11 no commit before CS fall", n_commit - bc, 0);

      // R4 write wiper, pot 1
      bc = n_commit;
      frame(ID_OK, {4'b1010, 2'b00, 1'b0, 1'b1}, 3, 8'h2A, r);
      check("R4 write wiper commits", n_commit - bc, 1);
      check("R4 write data", l_wd, 6'h2A);
      check("R3 opcode field", l_op, 4'b1010);
      check("R3 pot field", l_pot, 1);

      // R4 write stored register 2, pot 0
      bc = n_commit;
      frame(ID_OK, {4'b1100, 2'b10, 1'b0, 1'b0}, 3, 8'hD5, r);
      check("R4 write store commits", n_commit - bc, 1);
      check("R4 upper bits dropped", l_wd, 6'h15);
      check("R3 reg field", l_reg, 2);

      // R5 transfers
      bc = n_commit;
      frame(ID_OK, {4'b1101, 2'b11, 1'b0, 1'b1}, 2, 8'h00, r);
      check("R5 transfer commits", n_commit - bc, 1);
      check("R5 transfer reg", l_reg, 3);
      bc = n_commit;
      frame(ID_OK, {4'b0001, 2'b01, 1'b0, 1'b0}, 2, 8'h00, r);
      frame(ID_OK, {4'b1000, 2'b10, 1'b0, 1'b0}, 2, 8'h00, r);
      check("R5 global transfers commit", n_commit - bc, 2);
      check("R5 global save opcode", l_op, 4'b1000);
      bc = n_commit;
      open_frame();
      sbits(ID_OK, 7, 0, r);
      sbits({4'b1110, 2'b00, 1'b0, 1'b0}, 7, 0, r);
      sbits(8'h80, 7, 7, r);
      close_frame();
      check("R5 extra bit cancels", n_commit - bc, 0);

      // R2 identification mismatches
      bc = n_commit; br = n_rdreq;
      frame({4'b0110, 2'b00, STRAP}, {4'b1010, 4'b0000}, 3, 8'h11, r);
      frame({4'b0101, 2'b00, 2'b10}, {4'b1010, 4'b0000}, 3, 8'h11, r);
      frame({4'b0101, 2'b10, STRAP}, {4'b1001, 4'b0000}, 3, 8'h00, r);
      check("R2 bad id no commit", n_commit - bc, 0);
      check("R2 bad id no read", n_rdreq - br, 0);

      // R6 CS rises mid data byte
      bc = n_commit;
      open_frame();
      sbits(ID_OK, 7, 0, r);
      sbits({4'b1010, 4'b0000}, 7, 0, r);
      sbits(8'h3F, 7, 4, r);
      close_frame();
      check("R6 partial frame no commit", n_commit - bc, 0);

      // R7 read stored register 1, pot 0
      rd_data = 6'h2D;
      br = n_rdreq;
      frame(ID_OK, {4'b1011, 2'b01, 1'b0, 1'b0}, 3, 8'hFF, r);
      check("R7 read request", n_rdreq - br, 1);
      check("R7 read data on SO", r, 8'h2D);
      check("R3 read reg field", l_reg, 1);
      rd_data = 6'h01;
      frame(ID_OK, {4'b0101, 4'b0000}, 3, 8'h00, r);
      check("R7 status data on SO", r, 8'h01);
      check("R1 so_oe off after read", so_oe, 0);

      // R10 unknown opcode
      bc = n_commit; br = n_rdreq; bs = n_step;
      frame(ID_OK, {4'b0011, 4'b0001}, 3, 8'hAA, r);
      check("R10 unknown no commit", n_commit - bc, 0);
      check("R10 unknown no read/step", (n_rdreq - br) + (n_step - bs), 0);

      // R8 step command
      bs = n_step; bu = n_up;
      open_frame();
      sbits(ID_OK, 7, 0, r);
      sbits({4'b0010, 4'b0001}, 7, 0, r);
      sbits(8'b1101_0000, 7, 4, r);
      close_frame();
      check("R8 step count", n_step - bs, 4);
      check("R8 up steps", n_up - bu, 3);

      // R9 pause in a write frame
      bc = n_commit;
      open_frame();
      sbits(ID_OK, 7, 0, r);
      sbits({4'b1010, 4'b0000}, 7, 0, r);
      sbits(8'h1B, 7, 5, r);
      hold_n = 1'b0;
      wait_n(HALF);
      sbits(8'hFF, 7, 6, r);
      hold_n = 1'b1;
      wait_n(HALF);
      sbits(8'h1B, 4, 0, r);
      close_frame();
      check("R9 paused write commits", n_commit - bc, 1);
      check("R9 paused pulses ignored", l_wd, 6'h1B);

      // R9 pause in a read frame
      rd_data = 6'h33;
      r = '0;
      open_frame();
      begin
         logic [7:0] d;
         sbits(ID_OK, 7, 0, d);
         sbits({4'b1001, 4'b0001}, 7, 0, d);
         sbits(8'h00, 7, 5, r);
         hold_n = 1'b0;
         wait_n(2 * HALF);
         check("R9 so floats when paused", so_oe, 0);
         hold_n = 1'b1;
         wait_n(2 * HALF);
         check("R9 so returns after resume", so_oe, 1);
         sbits(8'h00, 4, 0, r);
      end
      close_frame();
      check("R9 read after pause", r, 8'h33);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule